// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block sits on the slave side of a three-wire serial write port made of an active-low frame select, a serial clock and a serial data input. A faster system clock oversamples all three lines through synchronizers and finds their edges. It then shifts one 16-bit command word in, most significant bit first, on falling serial-clock edges. When a frame completes, the word is split into a 2-bit power-down mode code and a 12-bit converter value. Both registers are loaded in the same cycle.

A frame completes on its 16th falling serial-clock edge, whether or not select is still low. If select is released early, the frame is dropped and an abort pulse is raised. Once a frame has committed, the receiver ignores further serial traffic until select has been high for a minimum number of system cycles and then falls again. The block outputs the converter value, the raw mode code and a one-hot decode of that code for the output switching logic. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_cmd_rx`

## Requirements
- R1: A frame starts only on a falling edge of `sel_n_i` that follows at least `MIN_HIGH_CYC` consecutive system cycles of `sel_n_i` high. A falling edge after a shorter high time starts no frame, and the serial clocks that follow it change nothing.
- R2: While a frame is open, `sdin_i` is sampled on each falling edge of `sclk_i`. The first bit sampled becomes bit 15 of the word, and the last becomes bit 0.
- R3: In the word, bits 15 and 14 have no effect, bits 13:12 form the mode code, and bits 11:0 form the converter value.
- R4: On the 16th falling `sclk_i` edge, `dac_data_o` and `pd_mode_o` both take their new values. This happens whether `sel_n_i` is then kept low or released.
- R5: If `sel_n_i` rises before the 16th falling edge, neither `dac_data_o` nor `pd_mode_o` changes, and `abort_o` pulses for one cycle.
- R6: `update_o` is high for exactly one system cycle per committed frame, in the same cycle that the new register values appear.
- R7: `mode_onehot_o` has exactly one bit set, at index equal to the mode code. Code 0 means normal operation, 1 means the output is tied to ground through 1 kΩ, 2 means through 100 kΩ, and 3 means high impedance.
- R8: After reset, `dac_data_o` is 0, `pd_mode_o` is 0, `mode_onehot_o` is 4'b0001, and `update_o` and `abort_o` are low.
- R9: After a commit with `sel_n_i` still low, further `sclk_i` edges change nothing and raise no `update_o` until `sel_n_i` rises and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdin_i | input | 1 | Serial data, asynchronous |
| dac_data_o | output | 12 | Converter value register |
| pd_mode_o | output | 2 | Power-down mode code register |
| mode_onehot_o | output | 4 | One-hot decode of the mode code |
| update_o | output | 1 | One-cycle pulse on each commit |
| abort_o | output | 1 | One-cycle pulse on each cut-short frame |

## Verification
The two hardest situations to reach are a frame that commits while select stays low and is then followed by more serial clocks, and a select fall that comes after too short a high time. The bench handles the first by keeping select low after the 16th edge and clocking in a second, different word that must be ignored. It handles the second by raising select for a single system cycle between two lows before sending a full word. Early release is swept over every bit count from 0 to 15.

// File: rtl/sdac_pkg.sv
// Package: shared constants and types for the serial DAC command receiver.
// Assumes a word made of 2 ignored bits, then the mode code, then the data.
package sdac_pkg;
    localparam int DATA_W = 12;
    localparam int MODE_W = 2;
    localparam int PAD_W  = 2;
    localparam int WORD_W = PAD_W + MODE_W + DATA_W;

    typedef enum logic [1:0] {
        FRM_IDLE  = 2'd0,
        FRM_SHIFT = 2'd1,
        FRM_DONE  = 2'd2
    } frm_state_t;
endpackage

// File: rtl/sdac_sync.sv
// Module: multi-stage synchronizer bank, one chain per input bit.
// Assumes the inputs are asynchronous levels that are stable for several clocks.
module sdac_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift each raw input through its own flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sdac_frame.sv
// Module: frame tracker and shift register for the serial write port.
// Works on synchronized levels, finds edges, shifts bits MSB first and raises
// a commit pulse on the 16th falling serial clock or an abort pulse when
// select rises early. Only the low PAYLOAD_W bits are kept, so the leading
// ignored bits fall off the top of the register.
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int WORD_BITS    = WORD_W,
    parameter int PAYLOAD_W    = MODE_W + DATA_W,
    parameter int MIN_HIGH_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n_s,
    input  logic                 sclk_s,
    input  logic                 sdin_s,
    output logic [PAYLOAD_W-1:0] payload_o,
    output logic                 commit_o,
    output logic                 abort_o
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam int HI_W  = $clog2(MIN_HIGH_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);
    localparam logic [HI_W-1:0]  HI_LIM   = HI_W'(MIN_HIGH_CYC);

    logic                 sel_p_q, sclk_p_q;
    logic [HI_W-1:0]      hi_cnt_q;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [PAYLOAD_W-1:0] shreg_q;
    frm_state_t           state_q;
    logic                 commit_q, abort_q;

    wire sel_fall  = sel_p_q & ~sel_n_s;
    wire sclk_fall = sclk_p_q & ~sclk_s;
    wire armed     = (hi_cnt_q == HI_LIM);

    // Keep one-cycle-old copies of the synchronized lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_p_q  <= 1'b1;
            sclk_p_q <= 1'b1;
        end else begin
            sel_p_q  <= sel_n_s;
            sclk_p_q <= sclk_s;
        end
    end

    // Count how long select has been high, saturating at the arming limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_cnt_q <= '0;
        else if (!sel_n_s)       hi_cnt_q <= '0;
        else if (!armed)         hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // Frame sequencing: open, shift, commit or abort, then wait for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FRM_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            commit_q  <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
            unique case (state_q)
                FRM_IDLE: begin
                    if (sel_fall && armed) begin
                        state_q   <= FRM_SHIFT;
                        bit_cnt_q <= '0;
                        shreg_q   <= '0;
                    end
                end
                FRM_SHIFT: begin
                    if (sel_n_s) begin
                        state_q <= FRM_IDLE;
                        shreg_q <= '0;
                        abort_q <= 1'b1;
                    end else if (sclk_fall) begin
                        shreg_q   <= {shreg_q[PAYLOAD_W-2:0], sdin_s};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (bit_cnt_q == LAST_BIT) begin
                            state_q  <= FRM_DONE;
                            commit_q <= 1'b1;
                        end
                    end
                end
                FRM_DONE: begin
                    if (sel_n_s) state_q <= FRM_IDLE;
                end
                default: state_q <= FRM_IDLE;
            endcase
        end
    end

    assign payload_o = shreg_q;
    assign commit_o  = commit_q;
    assign abort_o   = abort_q;

    // R1
    short_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRM_IDLE && sel_fall && !armed) |=> state_q == FRM_IDLE);
    // R4
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(sclk_fall));
    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRM_DONE) |=> !commit_o && !abort_o);
endmodule

// File: rtl/sdac_cmd_rx.sv
// Module: top of the serial DAC command receiver. Synchronizes the three
// serial lines, tracks frames and holds the converter value and mode code.
// Assumes the system clock is at least 4x the serial clock rate.
module sdac_cmd_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_HIGH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic [DATA_W-1:0] dac_data_o,
    output logic [MODE_W-1:0] pd_mode_o,
    output logic [(1<<MODE_W)-1:0] mode_onehot_o,
    output logic              update_o,
    output logic              abort_o
);
    localparam int PAYLOAD_W = MODE_W + DATA_W;
    localparam int N_MODES   = 1 << MODE_W;

    logic [2:0]           raw_lines, sync_lines;
    logic [PAYLOAD_W-1:0] payload;
    logic                 frm_commit, frm_abort;
    logic [DATA_W-1:0]    data_q;
    logic [MODE_W-1:0]    mode_q;
    logic                 upd_q, abt_q;

    assign raw_lines = {sel_n_i, sclk_i, sdin_i};

    sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_lines), .q_o(sync_lines)
    );

    sdac_frame #(.WORD_BITS(WORD_W), .PAYLOAD_W(PAYLOAD_W),
                 .MIN_HIGH_CYC(MIN_HIGH_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sel_n_s(sync_lines[2]), .sclk_s(sync_lines[1]), .sdin_s(sync_lines[0]),
        .payload_o(payload), .commit_o(frm_commit), .abort_o(frm_abort)
    );

    // Load mode and data together on commit; register the strobes alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mode_q <= '0;
            upd_q  <= 1'b0;
            abt_q  <= 1'b0;
        end else begin
            upd_q <= frm_commit;
            abt_q <= frm_abort;
            if (frm_commit) begin
                data_q <= payload[DATA_W-1:0];
                mode_q <= payload[PAYLOAD_W-1:DATA_W];
            end
        end
    end

    for (genvar m = 0; m < N_MODES; m++) begin : g_dec
        assign mode_onehot_o[m] = (mode_q == MODE_W'(m));
    end

    assign dac_data_o = data_q;
    assign pd_mode_o  = mode_q;
    assign update_o   = upd_q;
    assign abort_o    = abt_q;

    // R5
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_abort |=> $stable(data_q) && $stable(mode_q));
    // R6
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_commit |=> update_o && !$past(update_o));
    // R7
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_onehot_o) == 1);
endmodule

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb;
    localparam int HP = 4;   // system cycles per serial half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
    logic [11:0] dac_data;
    logic [1:0]  pd_mode;
    logic [3:0]  onehot;
    logic        upd, abt;
    int total = 0, bad = 0, upd_cnt = 0, abt_cnt = 0;
    logic [11:0] exp_data = '0;
    logic [1:0]  exp_mode = '0;

    always #4 clk = ~clk;

    sdac_cmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdin_i(sdin),
        .dac_data_o(dac_data), .pd_mode_o(pd_mode), .mode_onehot_o(onehot),
        .update_o(upd), .abort_o(abt)
    );

    always @(posedge clk) begin
        if (rst_n && upd) upd_cnt <= upd_cnt + 1;
        if (rst_n && abt) abt_cnt <= abt_cnt + 1;
    end

    task automatic sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [15:0] w, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) begin
            sdin = w[i];
            sys(HP);
            sclk = 1'b0;
            sys(HP);
            sclk = 1'b1;
        end
        sys(HP);
    endtask

    task automatic check_regs(input string req, input int n_upd);
        chk(req, dac_data, exp_data);
        chk(req, pd_mode, exp_mode);
        chk({req, "/R7"}, onehot, 4'b1 << exp_mode);
        chk({req, "/R6"}, upd_cnt, n_upd);
    endtask

    // R2 R3 R4: full frame with MSB first, then release select
    task automatic full_frame(input logic [15:0] w);
        int u0;
        u0 = upd_cnt;
        sel_n = 1'b0;
        sys(HP);
        shift_bits(w, 16);
        sel_n = 1'b1;
        sys(12);
        exp_data = w[11:0];
        exp_mode = w[13:12];
        check_regs("R2/R3/R4", u0 + 1);
    endtask

    initial begin
        int u0, a0;
        sys(5);
        // R8 reset state
        chk("R8", dac_data, 0);
        chk("R8", pd_mode, 0);
        chk("R8", onehot, 4'b0001);
        chk("R8", {upd, abt}, 0);
        rst_n = 1'b1;
        sys(10);
        chk("R8", dac_data, 0);

        // R2 R3 R7: sweep all mode codes, ignored bits and data patterns
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 10; k++) begin
                logic [11:0] d;
                d = 12'((k * 12'h1A7 + m * 12'h333) ^ (k[0] ? 12'hFFF : 12'h000));
                full_frame({2'(k), 2'(m), d});
            end
        end
        full_frame(16'h0FFF);
        full_frame(16'hC000);

        // R5: release select after 0..15 bits; nothing may change
        for (int n = 0; n < 16; n++) begin
            u0 = upd_cnt;
            a0 = abt_cnt;
            sel_n = 1'b0;
            sys(HP);
            shift_bits(16'h3ABC ^ 16'(n), n);
            sel_n = 1'b1;
            sys(12);
            check_regs("R5", u0);
            chk("R5 abort", abt_cnt, a0 + 1);
        end

        // R4 R9: commit with select held low, then another word is ignored
        u0 = upd_cnt;
        sel_n = 1'b0;
        sys(HP);
        shift_bits(16'h2345, 16);
        sys(8);
        exp_data = 12'h345;
        exp_mode = 2'd2;
        check_regs("R4 sel low", u0 + 1);
        shift_bits(16'h1F0F, 16);
        sys(8);
        check_regs("R9", u0 + 1);
        sel_n = 1'b1;
        sys(12);
        full_frame(16'h1ACE);

        // R1: select high for only one cycle before falling again
        u0 = upd_cnt;
        sel_n = 1'b0;
        sys(HP);
        sel_n = 1'b1;
        sys(1);
        sel_n = 1'b0;
        sys(HP);
        shift_bits(16'h3777, 16);
        sel_n = 1'b1;
        sys(12);
        check_regs("R1", u0);
        full_frame(16'h0123);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule